// File: doc/BRIEF.md
# One-Wire ROM Search Sequencer

This block runs one pass of the 64-bit ROM enumeration on a one-wire bus, sitting on top of a bus master that provides a bus-reset service and a byte-exchange service with a search accelerator. Each pass begins when `start` is pulsed. The sequencer asks the master for a bus reset and checks for a presence response. It then sends the search command byte and turns on accelerator mode. After that it runs sixteen byte exchanges. Each exchange carries four direction bits out and brings back four discrepancy flags and four selected bits.

The sequencer builds up the ROM code one nibble at a time, running a CRC-8 over the data bytes as the nibbles arrive. At the end it validates the code and updates its persistent search state: the last discrepancy position and the last-device flag. That state is kept between passes, so that repeated starts walk through every device on the bus. A pass started with `new_search` high restarts the walk from the beginning.

Top module: `ow_rom_walker`

## Requirements
- R1: A start with `new_search` high clears the stored last discrepancy position, the last-device flag and `rom_code` before the pass proceeds. `rom_code` reads zero in the cycle after that start.
- R2: A start while `last_device` is high and `new_search` is low produces a done pulse in the next cycle, with `found` low and `last_device` cleared, and issues no bus reset. Any other start issues a one-cycle `bus_rst_req` in the next cycle.
- R3: `accel_en` rises in the cycle after the search command byte exchange completes. It falls in the cycle after the sixteenth nibble exchange completes.
- R4: If the reset completes with `bus_presence` low, the pass ends with a done pulse and `found` low, and the stored search state is cleared. No byte exchange takes place. With presence, a one-cycle `xfer_req` carries the command byte 0xF0 on `xfer_wdata`.
- R5: Nibble n (0 to 15) covers bit positions 4n+1 to 4n+4, and bit j of the nibble is position 4n+j+1. Its request carries `xfer_wdata[7:4]`=0 and `xfer_wdata[3:0]` equal to `rom_code[4n+3:4n]` from the previous pass. If the stored last discrepancy position lies inside the nibble, the bit for that position is forced to 1. Each request is a one-cycle `xfer_req` issued in the cycle after the previous exchange completes.
- R6: In each response, `xfer_rdata[3:0]` holds the discrepancy flags and `xfer_rdata[7:4]` the selected bits. The selected bits replace `rom_code[4n+3:4n]`. Nibbles are processed in the order 0 to 15.
- R7: The candidate discrepancy is reset to 0 at every pass start. After each nibble it takes the highest position in that nibble whose discrepancy flag is 1 and whose selected bit is 0; a nibble with no such position leaves it unchanged. On success the stored position takes the candidate, and `last_device` is set if the candidate is 0.
- R8: A pass succeeds, and `found` goes high, only if two conditions hold. The CRC-8 of bytes 0 to 6 must equal `rom_code[63:56]`; the CRC is taken LSB first over byte 0 upward, with the reflected constant 0x8C and initial value 0. Byte 0 must also be nonzero. Otherwise `found` stays low and the stored state is cleared.
- R9: `done` is a one-cycle pulse in the cycle after a pass ends. `found` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one search pass (accepted when idle) |
| new_search | input | 1 | With start: restart enumeration from the beginning |
| bus_rst_req | output | 1 | One-cycle request for a bus reset |
| bus_rst_done | input | 1 | One-cycle reset completion from the master |
| bus_presence | input | 1 | Presence result, valid with bus_rst_done |
| xfer_req | output | 1 | One-cycle request for a byte exchange |
| xfer_wdata | output | 8 | Byte to send (command or direction nibble) |
| xfer_done | input | 1 | One-cycle exchange completion |
| xfer_rdata | input | 8 | Returned byte, valid with xfer_done |
| accel_en | output | 1 | Search accelerator mode for the master |
| rom_code | output | 64 | Assembled ROM code |
| found | output | 1 | Last pass found a valid device |
| done | output | 1 | One-cycle pass completion pulse |
| last_device | output | 1 | Enumeration has reached its final device |

## Verification
Three devices are placed on the bench with ROM codes that differ in the family code and in a serial byte. A full enumeration under that set checks the direction forcing and candidate tracking across passes, and a further start then shows the bus is left alone once the walk is finished. A single-device set separates a zero candidate (last device at once) from the multi-device case. An empty bus, a device with a corrupted CRC byte and a device with a zero family code each tell apart a different failure path that must clear the state. A new search issued partway through an enumeration shows that the stored state and code are really discarded.

// File: rtl/ow_walk_pkg.sv
package ow_walk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE = 3'd0,
        WS_RST  = 3'd1,
        WS_CMD  = 3'd2,
        WS_NIB  = 3'd3,
        WS_FIN  = 3'd4
    } walk_st_e;

endpackage

// File: rtl/ow_crc_nib.sv
// Advances a reflected CRC-8 by four data bits, least significant bit first.
module ow_crc_nib #(
    parameter logic [7:0] POLY = 8'h8C
) (
    input  logic [7:0] crc_in,
    input  logic [3:0] bits_in,
    output logic [7:0] crc_out
);
    logic [7:0] acc;
    logic       fb;

    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int j = 0; j < 4; j++) begin
            fb  = acc[0] ^ bits_in[j];
            acc = acc >> 1;
            if (fb) acc = acc ^ POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/ow_dir_gen.sv
// Builds the four direction bits for one nibble from the previous code.
module ow_dir_gen #(
    parameter int NIB_W = 4,
    parameter int PW    = 7
) (
    input  logic [NIB_W-1:0] nib_idx,
    input  logic [3:0]       prev_bits,
    input  logic [PW-1:0]    ldisc,
    output logic [3:0]       dir
);
    logic [PW-1:0] pm1;
    logic [PW-3:0] idx_ext;

    always_comb begin
        pm1     = ldisc - PW'(1);
        idx_ext = (PW-2)'(nib_idx);
        dir     = prev_bits;
        if ((ldisc != '0) && (pm1[PW-1:2] == idx_ext)) begin
            dir[pm1[1:0]] = 1'b1;
        end
    end
endmodule

// File: rtl/ow_nib_pick.sv
// Finds the highest position in a nibble where devices disagreed and 0 was taken.
module ow_nib_pick #(
    parameter int NIB_W = 4,
    parameter int PW    = 7
) (
    input  logic [NIB_W-1:0] nib_idx,
    input  logic [3:0]       disc,
    input  logic [3:0]       sel,
    input  logic [PW-1:0]    cand_in,
    output logic [PW-1:0]    cand_out
);
    always_comb begin
        cand_out = cand_in;
        for (int i = 0; i < 4; i++) begin
            if (disc[i] && !sel[i]) begin
                cand_out = PW'({nib_idx, 2'(i)}) + PW'(1);
            end
        end
    end
endmodule

// File: rtl/ow_rom_walker.sv
module ow_rom_walker
    import ow_walk_pkg::*;
#(
    parameter int          ROM_BITS   = 64,
    parameter logic [7:0]  SEARCH_CMD = 8'hF0,
    parameter logic [7:0]  CRC_POLY   = 8'h8C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                new_search,
    output logic                bus_rst_req,
    input  logic                bus_rst_done,
    input  logic                bus_presence,
    output logic                xfer_req,
    output logic [7:0]          xfer_wdata,
    input  logic                xfer_done,
    input  logic [7:0]          xfer_rdata,
    output logic                accel_en,
    output logic [ROM_BITS-1:0] rom_code,
    output logic                found,
    output logic                done,
    output logic                last_device
);
    localparam int NIBS     = ROM_BITS / 4;
    localparam int NIB_W    = $clog2(NIBS);
    localparam int PW       = $clog2(ROM_BITS + 1);
    localparam int CRC_NIBS = NIBS - 2;

    typedef struct packed {
        walk_st_e            st;
        logic [NIB_W-1:0]    nib;
        logic [ROM_BITS-1:0] rom;
        logic [7:0]          crc;
        logic [PW-1:0]       cand;
        logic [PW-1:0]       ldisc;
        logic                ldev;
        logic                found;
        logic                done;
        logic                rreq;
        logic                xreq;
        logic                accel;
        logic [7:0]          wdata;
    } regs_t;

    regs_t q_q, q_d;

    logic [NIB_W-1:0] dir_idx;
    logic [3:0]       dir_bits;
    logic [7:0]       crc_nx;
    logic [PW-1:0]    cand_nx;
    logic             pass_ok;

    assign dir_idx = (q_q.st == WS_CMD) ? '0 : q_q.nib + 1'b1;

    ow_dir_gen #(.NIB_W(NIB_W), .PW(PW)) u_dir (
        .nib_idx   (dir_idx),
        .prev_bits (q_q.rom[dir_idx*4 +: 4]),
        .ldisc     (q_q.ldisc),
        .dir       (dir_bits)
    );

    ow_crc_nib #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (q_q.crc),
        .bits_in (xfer_rdata[7:4]),
        .crc_out (crc_nx)
    );

    ow_nib_pick #(.NIB_W(NIB_W), .PW(PW)) u_pick (
        .nib_idx  (q_q.nib),
        .disc     (xfer_rdata[3:0]),
        .sel      (xfer_rdata[7:4]),
        .cand_in  (q_q.cand),
        .cand_out (cand_nx)
    );

    assign pass_ok = (q_q.crc == q_q.rom[ROM_BITS-1 -: 8]) && (q_q.rom[7:0] != 8'h00);

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        q_d.rreq = 1'b0;
        q_d.xreq = 1'b0;
        case (q_q.st)
            WS_IDLE: begin
                if (start) begin
                    q_d.found = 1'b0;
                    if (new_search) begin
                        q_d.rom   = '0;
                        q_d.ldisc = '0;
                        q_d.ldev  = 1'b0;
                    end
                    if (q_q.ldev && !new_search) begin
                        q_d.ldisc = '0;
                        q_d.ldev  = 1'b0;
                        q_d.done  = 1'b1;
                    end else begin
                        q_d.rreq = 1'b1;
                        q_d.st   = WS_RST;
                        q_d.cand = '0;
                        q_d.crc  = 8'h00;
                        q_d.nib  = '0;
                    end
                end
            end
            WS_RST: begin
                if (bus_rst_done) begin
                    if (bus_presence) begin
                        q_d.xreq  = 1'b1;
                        q_d.wdata = SEARCH_CMD;
                        q_d.st    = WS_CMD;
                    end else begin
                        q_d.ldisc = '0;
                        q_d.ldev  = 1'b0;
                        q_d.done  = 1'b1;
                        q_d.st    = WS_IDLE;
                    end
                end
            end
            WS_CMD: begin
                if (xfer_done) begin
                    q_d.accel = 1'b1;
                    q_d.xreq  = 1'b1;
                    q_d.wdata = {4'h0, dir_bits};
                    q_d.st    = WS_NIB;
                end
            end
            WS_NIB: begin
                if (xfer_done) begin
                    q_d.rom[q_q.nib*4 +: 4] = xfer_rdata[7:4];
                    q_d.cand = cand_nx;
                    if (q_q.nib < NIB_W'(CRC_NIBS)) q_d.crc = crc_nx;
                    if (q_q.nib == NIB_W'(NIBS - 1)) begin
                        q_d.accel = 1'b0;
                        q_d.st    = WS_FIN;
                    end else begin
                        q_d.nib   = q_q.nib + 1'b1;
                        q_d.xreq  = 1'b1;
                        q_d.wdata = {4'h0, dir_bits};
                    end
                end
            end
            WS_FIN: begin
                q_d.done = 1'b1;
                q_d.st   = WS_IDLE;
                if (pass_ok) begin
                    q_d.found = 1'b1;
                    q_d.ldisc = q_q.cand;
                    q_d.ldev  = (q_q.cand == '0);
                end else begin
                    q_d.ldisc = '0;
                    q_d.ldev  = 1'b0;
                end
            end
            default: q_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign bus_rst_req = q_q.rreq;
    assign xfer_req    = q_q.xreq;
    assign xfer_wdata  = q_q.wdata;
    assign accel_en    = q_q.accel;
    assign rom_code    = q_q.rom;
    assign found       = q_q.found;
    assign done        = q_q.done;
    assign last_device = q_q.ldev;

    AST_RST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_req |=> !bus_rst_req);                                   // R2
    AST_ACCEL_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !accel_en);                                             // R3
    AST_NO_REQ_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rst_req, xfer_req}));                              // R4
    AST_XFER_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);                                         // R5
    AST_LAST_NEEDS_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(last_device) |-> found);                                   // R7
    AST_FAMILY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (rom_code[7:0] != 8'h00));                             // R8
    AST_FOUND_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> done);                                          // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R9

endmodule

// File: tb/tb_ow_rom_walker.sv
module tb_ow_rom_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, new_search = 1'b0;
    logic        bus_rst_done = 1'b0, bus_presence = 1'b0;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rdata = 8'h00;
    logic        bus_rst_req, xfer_req, accel_en, found, done, last_device;
    logic [7:0]  xfer_wdata;
    logic [63:0] rom_code;

    always #2 clk = ~clk;

    ow_rom_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .new_search(new_search),
        .bus_rst_req(bus_rst_req), .bus_rst_done(bus_rst_done), .bus_presence(bus_presence),
        .xfer_req(xfer_req), .xfer_wdata(xfer_wdata), .xfer_done(xfer_done),
        .xfer_rdata(xfer_rdata), .accel_en(accel_en), .rom_code(rom_code),
        .found(found), .done(done), .last_device(last_device)
    );

    int n_cmp = 0, n_bad = 0;
    bit fin = 1'b0;

    logic [63:0] exp_rom = '0;
    logic        exp_found = 0, exp_done = 0, exp_dev = 0;
    logic        exp_rreq = 0, exp_xreq = 0, exp_accel = 0;
    logic [7:0]  exp_wdata = 8'h00;
    int          m_ld = 0;

    logic [63:0] dev_rom [4];
    int          dev_cnt = 0;
    logic [3:0]  active = '0;

    task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(rom_code, exp_rom, "R6 rom_code");
            chk(64'(found), 64'(exp_found), "R8 found");
            chk(64'(done), 64'(exp_done), "R9 done");
            chk(64'(last_device), 64'(exp_dev), "R7 last_device");
            chk(64'(accel_en), 64'(exp_accel), "R3 accel_en");
            chk(64'(bus_rst_req), 64'(exp_rreq), "R2 bus_rst_req");
            chk(64'(xfer_req), 64'(exp_xreq), "R5 xfer_req");
            chk(64'(xfer_wdata), 64'(exp_wdata), "R5 xfer_wdata");
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] crc8(input logic [63:0] r);
        logic [7:0] c = 8'h00;
        for (int b = 0; b < 7; b++) begin
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ r[b*8+i];
                c = c >> 1;
                if (fb) c = c ^ 8'h8C;
            end
        end
        return c;
    endfunction

    function automatic logic [63:0] make_rom(input logic [55:0] body);
        return {crc8({8'h00, body}), body};
    endfunction

    task automatic bus_nibble(input int n, input logic [3:0] dir, output logic [7:0] r);
        for (int j = 0; j < 4; j++) begin
            int  p = 4*n + j;
            bit  h1 = 0, h0 = 0, s;
            for (int k = 0; k < dev_cnt; k++)
                if (active[k]) begin
                    if (dev_rom[k][p]) h1 = 1; else h0 = 1;
                end
            if (h1 && h0) begin r[j] = 1'b1; s = dir[j]; end
            else begin r[j] = 1'b0; s = h0 ? 1'b0 : 1'b1; end
            r[4+j] = s;
            for (int k = 0; k < dev_cnt; k++)
                if (active[k] && dev_rom[k][p] != s) active[k] = 1'b0;
        end
    endtask

    task automatic run_pass(input logic ns);
        logic [3:0] d;
        logic [7:0] r;
        int c = 0;
        start = 1'b1; new_search = ns;
        tick;
        start = 1'b0; new_search = 1'b0;
        exp_found = 1'b0;
        if (ns) begin
            m_ld = 0; exp_dev = 1'b0; exp_rom = '0;
            chk(rom_code, 64'h0, "R1 code cleared by new search");
        end
        if (exp_dev) begin
            m_ld = 0; exp_dev = 1'b0; exp_done = 1'b1;
            tick;
            exp_done = 1'b0;
            chk(64'(found), 64'h0, "R2 early exit reports no device");
            return;
        end
        exp_rreq = 1'b1;
        tick; exp_rreq = 1'b0;
        tick;
        active = 4'hF;
        bus_rst_done = 1'b1; bus_presence = (dev_cnt > 0);
        tick;
        bus_rst_done = 1'b0; bus_presence = 1'b0;
        if (dev_cnt == 0) begin
            m_ld = 0; exp_dev = 1'b0; exp_done = 1'b1;
            tick;
            exp_done = 1'b0;
            chk(64'(found), 64'h0, "R4 no presence");
            return;
        end
        exp_xreq = 1'b1; exp_wdata = 8'hF0;
        tick; exp_xreq = 1'b0;
        tick;
        xfer_done = 1'b1; xfer_rdata = 8'hF0;
        tick;
        xfer_done = 1'b0;
        exp_accel = 1'b1;
        for (int n = 0; n < 16; n++) begin
            d = exp_rom[4*n +: 4];
            if (m_ld != 0 && (m_ld - 1) / 4 == n) d[(m_ld - 1) % 4] = 1'b1;
            exp_xreq = 1'b1; exp_wdata = {4'h0, d};
            tick; exp_xreq = 1'b0;
            tick;
            bus_nibble(n, d, r);
            xfer_rdata = r; xfer_done = 1'b1;
            tick;
            xfer_done = 1'b0;
            exp_rom[4*n +: 4] = r[7:4];
            for (int i = 3; i >= 0; i--)
                if (r[i] && !r[4+i]) begin c = 4*n + i + 1; break; end
        end
        exp_accel = 1'b0;
        tick;
        exp_done = 1'b1;
        if (crc8(exp_rom) == exp_rom[63:56] && exp_rom[7:0] != 8'h00) begin
            exp_found = 1'b1; m_ld = c; exp_dev = (c == 0);
        end else begin
            m_ld = 0; exp_dev = 1'b0;
        end
        tick;
        exp_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk({rom_code[61:0], found, done}, 64'h0, "R9 reset state");
        chk({61'h0, last_device, accel_en, xfer_req}, 64'h0, "R3 reset state");
        rst_n = 1'b1;
        tick;

        // Three devices: differ in family code and in a serial byte.
        dev_rom[0] = make_rom(56'h00_0000_0A15_0128);
        dev_rom[1] = make_rom(56'h00_0000_0A35_0128);
        dev_rom[2] = make_rom(56'h00_0000_0A15_0110);
        dev_cnt = 3;
        run_pass(1'b1);
        chk(64'(found), 64'h1, "R8 first device found");
        for (int p = 0; p < 5 && !exp_dev; p++) begin
            tick;
            run_pass(1'b0);
        end
        chk(64'(last_device), 64'h1, "R7 enumeration reaches last device");
        tick;
        run_pass(1'b0);
        chk(64'(last_device), 64'h0, "R2 state cleared after final device");

        // New search in the middle of an enumeration.
        tick; run_pass(1'b1);
        tick; run_pass(1'b0);
        tick; run_pass(1'b1);
        chk(64'(found), 64'h1, "R1 restarted walk finds a device");

        // Empty bus.
        dev_cnt = 0;
        tick; run_pass(1'b0);
        chk(64'(last_device), 64'h0, "R4 state cleared on no presence");

        // Corrupted CRC byte.
        dev_rom[0] = make_rom(56'h00_1234_5678_9A28) ^ 64'h1000_0000_0000_0000;
        dev_cnt = 1;
        tick; run_pass(1'b1);
        chk(64'(found), 64'h0, "R8 bad CRC rejected");

        // Zero family code with valid CRC.
        dev_rom[0] = make_rom(56'h00_1234_5678_9A00);
        tick; run_pass(1'b1);
        chk(64'(found), 64'h0, "R8 zero family rejected");

        // Single good device: candidate stays 0, last device at once.
        dev_rom[0] = make_rom(56'h00_00AB_CDEF_0133);
        tick; run_pass(1'b1);
        chk(64'(found), 64'h1, "R8 single device found");
        chk(64'(last_device), 64'h1, "R7 zero candidate sets last device");
        chk(rom_code, dev_rom[0], "R6 single device code");
        tick; run_pass(1'b0);
        chk(64'(done | bus_rst_req), 64'h0, "R2 quiet after early exit");

        repeat (3) tick;
        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule